// File: doc/BRIEF.md
# Multi-Mode Word Shifter

This block shifts or rotates one data word in a single combinational pass. It covers logical right shift, arithmetic right shift, logical left shift and rotation in either direction. All of these run through one right-only cyclic rotator. A bit mask and a fill value are generated next to the rotator, and they decide which result positions keep the rotated bit and which take the fill.

A left move by `s` becomes a right rotation by `(WIDTH - s) mod WIDTH`. The positions that wrapped around are then overwritten, or left alone in rotate mode. Because the rotator has only one direction, there is no second shifter and no reversal network.

The rotator has two build options, chosen by a parameter: a logarithmic stage chain, or a direct one-level selector per output bit. The port behaviour is the same for both.

Top module: `multimode_shifter`

## Requirements
- R1: With `shift_mode` = 2'b00 and `go_left` = 0, `result` equals `data_in` shifted right by `shift_amt`, and the vacated upper `shift_amt` bits are 0.
- R2: With `shift_mode` = 2'b01 and `go_left` = 0, `result` equals `data_in` shifted right by `shift_amt`, and the vacated upper bits are copies of `data_in[WIDTH-1]`.
- R3: With `shift_mode[1]` = 1 (codes 2'b10 and 2'b11), no bits are cleared. A right rotation moves bit `i+s` to bit `i`, a left rotation moves bit `i` to bit `i+s` (indices mod WIDTH), and the count of set bits is kept.
- R4: With `shift_mode` = 2'b00 or 2'b01 and `go_left` = 1, `result` equals `data_in` shifted left by `shift_amt`, and the low `shift_amt` bits are 0. An arithmetic left move is the same as a logical left move.
- R5: With `shift_amt` = 0, `result` equals `data_in` for every mode and direction.
- R6: At the largest amount (WIDTH-1), a right logical shift leaves only bit 0 (the old top bit), a right arithmetic shift gives all copies of the sign bit, and a left shift leaves only the top bit (the old bit 0).
- R7: The output is a pure combinational function of the inputs. Both rotator build options (`ROT_STYLE` 0 and 1) give the same result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | WIDTH | Word to shift or rotate |
| shift_amt | input | AMT_W | Number of bit positions, 0 to WIDTH-1 |
| go_left | input | 1 | 0 = move toward bit 0, 1 = move toward the top bit |
| shift_mode | input | 2 | 00 logical, 01 arithmetic, 1x rotate |
| result | output | WIDTH | Shifted or rotated word |

## Verification
The bench targets the points where the left-to-right translation and the mask can go wrong.

- Amount 0: a translation that forgets the mod-WIDTH wrap would rotate by a full WIDTH, or would mask every bit during a left shift.
- The largest amount: a mask with an off-by-one edge keeps or clears one bit too many.
- Negative words under an arithmetic right shift: a fill taken from the wrong bit, or not applied, shows up as zeros at the top.
- Arithmetic mode with a left move: a design that sign-fills the low end would put ones there.
- The reserved rotate code 2'b11: a rotate test that only decodes 2'b10 would start masking for this code.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

   typedef enum logic [1:0] {
      SHM_LOGIC      = 2'b00,
      SHM_ARITH      = 2'b01,
      SHM_ROTATE     = 2'b10,
      SHM_ROTATE_ALT = 2'b11
   } shift_mode_e;

   localparam int ROT_LOG    = 0;
   localparam int ROT_DIRECT = 1;

   function automatic logic mode_is_rotate(input logic [1:0] m);
      return m[1];
   endfunction

   function automatic logic mode_is_arith(input logic [1:0] m);
      return (m == SHM_ARITH);
   endfunction

endpackage

// File: rtl/amount_xlate.sv
module amount_xlate #(
   parameter int WIDTH = 32,
   parameter int AMT_W = $clog2(WIDTH)
) (
   input  logic [AMT_W-1:0] amt,
   input  logic             go_left,
   output logic [AMT_W-1:0] rot_amt
);
   // Left by s == right by (WIDTH - s) mod WIDTH; WIDTH is 2**AMT_W,
   // so the modulo is the natural wrap of the AMT_W-bit subtraction.
   logic [AMT_W-1:0] neg_amt;

   always_comb begin
      neg_amt = '0 - amt;
      rot_amt = go_left ? neg_amt : amt;
   end
endmodule

// File: rtl/rotr_core.sv
module rotr_core #(
   parameter int WIDTH     = 32,
   parameter int AMT_W     = $clog2(WIDTH),
   parameter int ROT_STYLE = 0
) (
   input  logic [WIDTH-1:0] din,
   input  logic [AMT_W-1:0] amt,
   output logic [WIDTH-1:0] dout
);
   import shifter_pkg::*;

   generate
      if (ROT_STYLE == ROT_LOG) begin : g_log
         logic [WIDTH-1:0] stage [AMT_W+1];
         assign stage[0] = din;
         for (genvar k = 0; k < AMT_W; k++) begin : g_stage
            localparam int STEP = 2 ** k;
            logic [WIDTH-1:0] turned;
            assign turned       = {stage[k][STEP-1:0], stage[k][WIDTH-1:STEP]};
            assign stage[k+1]   = amt[k] ? turned : stage[k];
         end
         assign dout = stage[AMT_W];
      end else if (ROT_STYLE == ROT_DIRECT) begin : g_direct
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic [AMT_W-1:0] src;
            assign src     = AMT_W'(i) + amt;
            assign dout[i] = din[src];
         end
      end else begin : g_bad
         $error("rotr_core: ROT_STYLE must be 0 or 1");
      end
   endgenerate
endmodule

// File: rtl/fill_mask_gen.sv
module fill_mask_gen #(
   parameter int WIDTH = 32,
   parameter int AMT_W = $clog2(WIDTH)
) (
   input  logic [AMT_W-1:0] amt,
   input  logic             go_left,
   input  logic [1:0]       mode,
   input  logic             sign_bit,
   output logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] fill
);
   import shifter_pkg::*;

   localparam int CW = AMT_W + 1;

   logic             no_mask;
   logic             fill_bit;
   logic [WIDTH-1:0] hi_therm;
   logic [WIDTH-1:0] lo_therm;

   assign no_mask  = mode_is_rotate(mode);
   assign fill_bit = mode_is_arith(mode) && !go_left && sign_bit;

   // hi_therm: the top amt positions; lo_therm: the bottom amt positions
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_therm
         logic [CW-1:0] pos;
         logic [CW-1:0] sum;
         assign pos         = CW'(i);
         assign sum         = pos + {1'b0, amt};
         assign hi_therm[i] = (sum >= CW'(WIDTH));
         assign lo_therm[i] = (pos < {1'b0, amt});
      end
   endgenerate

   always_comb begin
      if (no_mask)      mask = '0;
      else if (go_left) mask = lo_therm;
      else              mask = hi_therm;
      fill = {WIDTH{fill_bit}};
   end
endmodule

// File: rtl/multimode_shifter.sv
module multimode_shifter #(
   parameter int WIDTH     = 32,
   parameter int AMT_W     = $clog2(WIDTH),
   parameter int ROT_STYLE = 0
) (
   input  logic [WIDTH-1:0] data_in,
   input  logic [AMT_W-1:0] shift_amt,
   input  logic             go_left,
   input  logic [1:0]       shift_mode,
   output logic [WIDTH-1:0] result
);
   generate
      if (WIDTH < 2) begin : g_chk_w
         $error("multimode_shifter: WIDTH must be at least 2");
      end
      if ((1 << AMT_W) != WIDTH) begin : g_chk_pow
         $error("multimode_shifter: WIDTH must equal 2**AMT_W");
      end
   endgenerate

   logic [AMT_W-1:0] rot_amt;
   logic [WIDTH-1:0] rotated;
   logic [WIDTH-1:0] mask;
   logic [WIDTH-1:0] fill;

   amount_xlate #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_xlate (
      .amt     (shift_amt),
      .go_left (go_left),
      .rot_amt (rot_amt)
   );

   rotr_core #(.WIDTH(WIDTH), .AMT_W(AMT_W), .ROT_STYLE(ROT_STYLE)) u_rot (
      .din  (data_in),
      .amt  (rot_amt),
      .dout (rotated)
   );

   fill_mask_gen #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_mask (
      .amt      (shift_amt),
      .go_left  (go_left),
      .mode     (shift_mode),
      .sign_bit (data_in[WIDTH-1]),
      .mask     (mask),
      .fill     (fill)
   );

   assign result = (rotated & ~mask) | (fill & mask);
endmodule

// File: rtl/multimode_shifter_chk.sv
module multimode_shifter_chk #(
   parameter int WIDTH = 32,
   parameter int AMT_W = $clog2(WIDTH)
) (
   input logic [WIDTH-1:0] data_in,
   input logic [AMT_W-1:0] shift_amt,
   input logic             go_left,
   input logic [1:0]       shift_mode,
   input logic [WIDTH-1:0] result,
   input logic [WIDTH-1:0] rotated
);
   logic [WIDTH-1:0] ref_rl;
   logic [WIDTH-1:0] ref_ra;
   logic [WIDTH-1:0] ref_l;

   always_comb begin
      ref_rl = data_in >> shift_amt;
      ref_ra = WIDTH'($signed(data_in) >>> shift_amt);
      ref_l  = data_in << shift_amt;
      if (shift_amt == '0) begin
         AST_ZERO_AMT_PASS: assert (result == data_in); // R5
      end
      if (!go_left && shift_mode == 2'b00) begin
         AST_RIGHT_LOGIC: assert (result == ref_rl); // R1
      end
      if (!go_left && shift_mode == 2'b01) begin
         AST_RIGHT_ARITH: assert (result == ref_ra); // R2
      end
      if (go_left && !shift_mode[1]) begin
         AST_LEFT_ZERO_FILL: assert (result == ref_l); // R4
      end
      if (shift_mode[1]) begin
         AST_ROT_KEEPS_BITS: assert ($countones(result) == $countones(data_in)); // R3
         AST_ROT_NO_MASK: assert (result == rotated); // R3
      end
   end
endmodule

bind multimode_shifter multimode_shifter_chk #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (
   .data_in    (data_in),
   .shift_amt  (shift_amt),
   .go_left    (go_left),
   .shift_mode (shift_mode),
   .result     (result),
   .rotated    (rotated)
);

// File: tb/sim_multimode_shifter.sv
`timescale 1ns/1ps
module sim_multimode_shifter;
   localparam int W  = 32;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [W-1:0]  data_in = '0;
   logic [AW-1:0] shift_amt = '0;
   logic          go_left = 1'b0;
   logic [1:0]    shift_mode = 2'b00;
   logic [W-1:0]  result;
   logic [W-1:0]  result_d;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   multimode_shifter #(.WIDTH(W), .AMT_W(AW), .ROT_STYLE(0)) u0 (
      .data_in, .shift_amt, .go_left, .shift_mode, .result
   );

   multimode_shifter #(.WIDTH(W), .AMT_W(AW), .ROT_STYLE(1)) u1 (
      .data_in, .shift_amt, .go_left, .shift_mode, .result(result_d)
   );

   typedef struct packed {
      logic [W-1:0]  d;
      logic [AW-1:0] a;
      logic          l;
      logic [1:0]    m;
      logic [W-1:0]  e;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VT [NV] = '{
      '{32'h8000_0000, 5'd4,  1'b0, 2'b00, 32'h0800_0000},
      '{32'h8000_0000, 5'd4,  1'b0, 2'b01, 32'hF800_0000},
      '{32'h0000_000F, 5'd4,  1'b0, 2'b10, 32'hF000_0000},
      '{32'h1234_5678, 5'd8,  1'b1, 2'b00, 32'h3456_7800},
      '{32'h1234_5678, 5'd8,  1'b1, 2'b01, 32'h3456_7800},
      '{32'h1234_5678, 5'd8,  1'b1, 2'b10, 32'h3456_7812},
      '{32'hFFFF_FFFF, 5'd31, 1'b0, 2'b00, 32'h0000_0001},
      '{32'h7FFF_FFFF, 5'd31, 1'b0, 2'b01, 32'h0000_0000},
      '{32'h8000_0000, 5'd31, 1'b0, 2'b01, 32'hFFFF_FFFF},
      '{32'hFFFF_FFFF, 5'd31, 1'b1, 2'b00, 32'h8000_0000},
      '{32'hA5A5_5A5A, 5'd0,  1'b0, 2'b10, 32'hA5A5_5A5A},
      '{32'hDEAD_BEEF, 5'd16, 1'b0, 2'b11, 32'hBEEF_DEAD}
   };

   function automatic logic [W-1:0] model(input logic [W-1:0] d, input int a,
                                          input logic l, input logic [1:0] m);
      if (a == 0) return d;
      if (m[1]) begin
         if (l) return (d << a) | (d >> (W - a));
         return (d >> a) | (d << (W - a));
      end
      if (l) return d << a;
      if (m == 2'b01) return W'($signed(d) >>> a);
      return d >> a;
   endfunction

   function automatic string req_of(input int a, input logic l, input logic [1:0] m);
      if (a == 0) return "R5";
      if (a == W - 1 && !m[1]) return "R6";
      if (m[1]) return "R3";
      if (l) return "R4";
      if (m == 2'b01) return "R2";
      return "R1";
   endfunction

   task automatic apply(input logic [W-1:0] d, input int a, input logic l,
                        input logic [1:0] m, input logic [W-1:0] exp, input string rq);
      @(posedge clk);
      data_in    <= d;
      shift_amt  <= AW'(a);
      go_left    <= l;
      shift_mode <= m;
      @(negedge clk);
      total++;
      if (result !== exp) begin
         bad++;
         $display("FAIL %s d=%h a=%0d left=%0b mode=%b got=%h exp=%h",
                  rq, d, a, l, m, result, exp);
      end
      total++;
      if (result_d !== exp) begin
         bad++;
         $display("FAIL R7 direct style d=%h a=%0d left=%0b mode=%b got=%h exp=%h",
                  d, a, l, m, result_d, exp);
      end
   endtask

   initial begin
      #200000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired got=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] pats [6];
      repeat (3) @(posedge clk);
      rst_n <= 1'b1;
      // R5: idle inputs (zero word, zero amount) pass straight through
      @(negedge clk);
      total++;
      if (result !== '0) begin
         bad++;
         $display("FAIL R5 idle got=%h exp=%h", result, 32'h0);
      end

      // vector table
      for (int i = 0; i < NV; i++) begin
         apply(VT[i].d, int'(VT[i].a), VT[i].l, VT[i].m, VT[i].e,
               req_of(int'(VT[i].a), VT[i].l, VT[i].m));
      end

      // sweep: every mode, both directions, every amount, corner and random data
      pats[0] = '0;
      pats[1] = '1;
      pats[2] = 32'h8000_0000;
      pats[3] = 32'h0000_0001;
      pats[4] = $urandom();
      pats[5] = $urandom() | 32'h8000_0000;
      for (int m = 0; m < 4; m++) begin
         for (int l = 0; l < 2; l++) begin
            for (int a = 0; a < W; a++) begin
               for (int p = 0; p < 6; p++) begin
                  apply(pats[p], a, l[0], m[1:0],
                        model(pats[p], a, l[0], m[1:0]), req_of(a, l[0], m[1:0]));
               end
            end
         end
      end

      // R4: arithmetic left on a negative word must not sign-fill the low end
      apply(32'hF000_0001, 3, 1'b1, 2'b01, 32'h8000_0008, "R4");
      // R3: reserved code 11 rotates left with no masking
      apply(32'h8000_0001, 1, 1'b1, 2'b11, 32'h0000_0003, "R3");
      // R6: largest amount, arithmetic on positive word
      apply(32'h4000_0000, W - 1, 1'b0, 2'b01, 32'h0000_0000, "R6");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule